// File: doc/BRIEF.md
# Binary and Packed-BCD Add/Subtract Unit

This block adds or subtracts two bytes with a carry input. It works in plain binary or in packed BCD, with two digits per byte. A variant select chooses between an early and a late processor personality. The two personalities give the same binary results. They differ in decimal mode, both in how the result is corrected and in where the negative, zero and overflow flags come from. The late personality also charges one extra cycle for a decimal operation, and the block reports that on an output.

The arithmetic is combinational and ends in a registered output stage that can be switched off by a parameter. A surrounding core applies the accumulator, the operand, the incoming carry, the decimal flag and the operation select. It reads the result byte and four flags one clock later. Nibbles outside the decimal range 0 to 9 are not rejected. They pass through the same correction steps as valid digits, so the results match bit for bit.

Top module: `bcd_addsub`

## Requirements
- R1: Binary add (dec_i=0, sub_i=0) gives res=(A+M+C) mod 256. carry is set when A+M+C exceeds 255. ovf is set when A and M have equal bit 7 and the result's bit 7 differs from A's. zero and neg come from the result. The same holds for both variants.
- R2: Binary subtract (dec_i=0, sub_i=1) gives res=(A-M-(1-C)) mod 256. carry=1 means no borrow, that is A >= M+(1-C). ovf is set when A and M differ in bit 7 and the result's bit 7 differs from A's. zero and neg come from the result. The same holds for both variants.
- R3: Early decimal add (late_i=0): lo = A[3:0]+M[3:0]+C, plus 6 if lo exceeds 9. v = lo[3:0]+A[7:4]*16+M[7:4]*16, plus 16 if lo exceeds 15. Then 0x60 is added to v if v[8:4] exceeds 9. carry = (corrected v >= 0x100), and res is its low byte.
- R4: Early decimal add flags: zero is set when (A+M+C) mod 256 is zero. neg is bit 7 of v before the 0x60 correction. ovf is set when A and M share bit 7 and that uncorrected v's bit 7 differs from A's.
- R5: Early decimal subtract: d = A[3:0]-M[3:0]-(1-C), signed. If d is negative, d-6 keeps its low nibble and the high part is A[7:4]*16-M[7:4]*16-16. Otherwise the high part is the same without the -16. If the combined signed value is negative, 0x60 is subtracted. res is its low byte.
- R6: Early decimal subtract flags: carry, neg, zero and ovf are exactly those of the binary subtract of R2.
- R7: Late decimal add: lo = A[3:0]+M[3:0]+C. If lo >= 10, lo becomes 16+((lo+6) mod 16). s = lo+A[7:4]*16+M[7:4]*16. If s >= 0xA0 then carry=1 and 0x60 is added, otherwise carry=0. ovf starts as "A and M share bit 7". It is cleared when s >= 0x180, or when carry=0 and s < 0x80. neg and zero come from the final res.
- R8: Late decimal subtract: t = 15+A[3:0]-M[3:0]+C. If t < 16, h=0 and t is reduced by 6. Otherwise h=16 and t is reduced by 16. Then h += 0xF0+A[7:4]*16-M[7:4]*16. If h < 0x100, carry=0 and 0x60 is taken from h. Otherwise carry=1. ovf starts as "A and M differ in bit 7". It is cleared when h < 0x80 with carry=0, or h >= 0x180 with carry=1. res = (h+t) mod 256. neg and zero come from res.
- R9: extra_cyc_o is 1 exactly when dec_i=1 and late_i=1.
- R10: In decimal mode, nibbles A to F in either input follow the same steps with no validation or clamping.
- R11: With the output stage on (default), all outputs update on the rising edge after the inputs are applied. A synchronous active-high reset clears every output to 0.
- R12: When both inputs hold valid BCD digits, both variants give a valid BCD result. For add, res+100*carry = A+M+C as decimal numbers. For subtract, res-100*(1-carry) = A-M-(1-C) as decimal numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset of the outputs |
| acc_i | input | 8 | Accumulator operand A |
| opnd_i | input | 8 | Memory operand M |
| carry_i | input | 1 | Incoming carry (1 = no borrow for subtract) |
| dec_i | input | 1 | 1 selects packed-BCD arithmetic |
| sub_i | input | 1 | 1 selects subtract, 0 add |
| late_i | input | 1 | 1 selects late-variant decimal behaviour |
| res_o | output | 8 | Result byte |
| carry_o | output | 1 | Carry out / no-borrow |
| zero_o | output | 1 | Zero flag |
| neg_o | output | 1 | Negative flag |
| ovf_o | output | 1 | Overflow flag |
| extra_cyc_o | output | 1 | One extra cycle is charged |

## Verification
Every result and flag, and the extra-cycle output, appears one rising edge after its inputs are applied. Nothing is due earlier. The bench changes the inputs on a falling edge, waits through exactly one rising edge, and compares all outputs on the next falling edge. It also checks once that the outputs still hold their old value before that edge. Expected values come from an integer model of the requirement formulas. The sweep covers every accumulator value against a set of operands rich in A to F nibbles, in all mode combinations, and then every pair of valid BCD digits in both variants.

// File: rtl/bcd_addsub_pkg.sv
package bcd_addsub_pkg;
  localparam int DW = 8;
  localparam int NW = 4;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          z;
    logic          n;
    logic          v;
  } arith_t;

  function automatic logic bcd_ok(input logic [DW-1:0] b);
    return (b[DW-1:NW] <= 4'd9) && (b[NW-1:0] <= 4'd9);
  endfunction

  function automatic int bcd_val(input logic [DW-1:0] b);
    return int'(b[DW-1:NW]) * 10 + int'(b[NW-1:0]);
  endfunction
endpackage

// File: rtl/bcd_addsub_bin.sv
module bcd_addsub_bin
  import bcd_addsub_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  input  logic          sub_i,
  output arith_t        out_o
);
  logic [DW-1:0] m_eff;
  logic [DW:0]   sum;
  logic [DW-1:0] undo;

  always_comb begin
    m_eff       = sub_i ? ~m_i : m_i;
    sum         = {1'b0, a_i} + {1'b0, m_eff} + {{DW{1'b0}}, c_i};
    out_o.res   = sum[DW-1:0];
    out_o.c     = sum[DW];
    out_o.z     = (sum[DW-1:0] == '0);
    out_o.n     = sum[DW-1];
    out_o.v     = (a_i[DW-1] == m_eff[DW-1]) && (sum[DW-1] != a_i[DW-1]);
  end

  // R2: adding back the operand and the borrow restores the accumulator
  always_comb begin
    undo = out_o.res + m_i + {{(DW-1){1'b0}}, ~c_i};
    if (sub_i && !$isunknown({a_i, m_i, c_i}))
      a_r2_sub_undo: assert (undo == a_i) else $error("R2 subtract does not invert");
  end
endmodule

// File: rtl/bcd_addsub_dec_early.sv
module bcd_addsub_dec_early
  import bcd_addsub_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  input  logic          sub_i,
  input  arith_t        bin_i,
  output arith_t        out_o
);
  localparam int XW = DW + 2;
  localparam int SW = DW + 4;

  logic [NW+1:0] lo;
  logic [XW-1:0] raw, fix;
  logic [SW-1:0] dlo, hi, dv;

  always_comb begin
    // add path
    lo = {2'b0, a_i[NW-1:0]} + {2'b0, m_i[NW-1:0]} + {{(NW+1){1'b0}}, c_i};
    if (lo > 6'd9) lo = lo + 6'd6;
    raw = {{(XW-NW){1'b0}}, lo[NW-1:0]}
        + {2'b0, a_i[DW-1:NW], {NW{1'b0}}}
        + {2'b0, m_i[DW-1:NW], {NW{1'b0}}}
        + ((lo > 6'd15) ? XW'(16) : XW'(0));
    fix = (raw[DW:NW] > 5'd9) ? raw + XW'(96) : raw;
    // subtract path, signed in SW bits
    dlo = {{(SW-NW){1'b0}}, a_i[NW-1:0]} - {{(SW-NW){1'b0}}, m_i[NW-1:0]}
        - {{(SW-1){1'b0}}, ~c_i};
    hi  = {4'b0, a_i[DW-1:NW], {NW{1'b0}}} - {4'b0, m_i[DW-1:NW], {NW{1'b0}}};
    if (dlo[NW]) dv = ((dlo - SW'(6)) & SW'(15)) | (hi - SW'(16));
    else         dv = (dlo & SW'(15)) | hi;
    if (dv[DW]) dv = dv - SW'(96);

    if (sub_i) begin
      out_o     = bin_i;
      out_o.res = dv[DW-1:0];
    end else begin
      out_o.res = fix[DW-1:0];
      out_o.c   = (fix[XW-1:DW] != '0);
      out_o.z   = bin_i.z;
      out_o.n   = raw[DW-1];
      out_o.v   = (a_i[DW-1] == m_i[DW-1]) && (raw[DW-1] != a_i[DW-1]);
    end
  end

  // R12: valid digits in give a correct decimal answer
  always_comb begin
    if (!$isunknown({a_i, m_i, c_i, sub_i}) && bcd_ok(a_i) && bcd_ok(m_i)) begin
      if (!sub_i)
        a_r12_early_add: assert (bcd_ok(out_o.res) &&
          bcd_val(out_o.res) + (out_o.c ? 100 : 0) == bcd_val(a_i) + bcd_val(m_i) + int'(c_i))
          else $error("R12 early decimal add");
      else
        a_r12_early_sub: assert (bcd_ok(out_o.res) &&
          bcd_val(out_o.res) + bcd_val(m_i) + int'(!c_i) == bcd_val(a_i) + (out_o.c ? 0 : 100))
          else $error("R12 early decimal subtract");
    end
  end
endmodule

// File: rtl/bcd_addsub_dec_late.sv
module bcd_addsub_dec_late
  import bcd_addsub_pkg::*;
(
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] m_i,
  input  logic          c_i,
  input  logic          sub_i,
  output arith_t        out_o
);
  localparam int SW = DW + 4;

  logic [NW:0]   lo;
  logic [SW-1:0] s, t, h, d;
  logic          v_add, v_sub, c_add, c_sub;
  logic [DW-1:0] r;

  always_comb begin
    // add path
    lo = {1'b0, a_i[NW-1:0]} + {1'b0, m_i[NW-1:0]} + {{NW{1'b0}}, c_i};
    if (lo >= 5'd10) lo = {1'b1, lo[NW-1:0] + 4'd6};
    s = {{(SW-NW-1){1'b0}}, lo} + {4'b0, a_i[DW-1:NW], {NW{1'b0}}}
      + {4'b0, m_i[DW-1:NW], {NW{1'b0}}};
    v_add = (a_i[DW-1] == m_i[DW-1]);
    if (s >= SW'(160)) begin
      c_add = 1'b1;
      if (s >= SW'(384)) v_add = 1'b0;
      s = s + SW'(96);
    end else begin
      c_add = 1'b0;
      if (s < SW'(128)) v_add = 1'b0;
    end
    // subtract path
    t = SW'(15) + {{(SW-NW){1'b0}}, a_i[NW-1:0]} - {{(SW-NW){1'b0}}, m_i[NW-1:0]}
      + {{(SW-1){1'b0}}, c_i};
    if (t < SW'(16)) begin
      h = '0;
      t = t - SW'(6);
    end else begin
      h = SW'(16);
      t = t - SW'(16);
    end
    h = h + SW'(240) + {4'b0, a_i[DW-1:NW], {NW{1'b0}}} - {4'b0, m_i[DW-1:NW], {NW{1'b0}}};
    v_sub = (a_i[DW-1] != m_i[DW-1]);
    if (h < SW'(256)) begin
      c_sub = 1'b0;
      if (h < SW'(128)) v_sub = 1'b0;
      h = h - SW'(96);
    end else begin
      c_sub = 1'b1;
      if (h >= SW'(384)) v_sub = 1'b0;
    end
    d = h + t;

    r         = sub_i ? d[DW-1:0] : s[DW-1:0];
    out_o.res = r;
    out_o.c   = sub_i ? c_sub : c_add;
    out_o.v   = sub_i ? v_sub : v_add;
    out_o.n   = r[DW-1];
    out_o.z   = (r == '0);
  end

  // R12: valid digits in give a correct decimal answer
  always_comb begin
    if (!$isunknown({a_i, m_i, c_i, sub_i}) && bcd_ok(a_i) && bcd_ok(m_i)) begin
      if (!sub_i)
        a_r12_late_add: assert (bcd_ok(out_o.res) &&
          bcd_val(out_o.res) + (out_o.c ? 100 : 0) == bcd_val(a_i) + bcd_val(m_i) + int'(c_i))
          else $error("R12 late decimal add");
      else
        a_r12_late_sub: assert (bcd_ok(out_o.res) &&
          bcd_val(out_o.res) + bcd_val(m_i) + int'(!c_i) == bcd_val(a_i) + (out_o.c ? 0 : 100))
          else $error("R12 late decimal subtract");
    end
  end
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_addsub_pkg::*;
#(
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          carry_i,
  input  logic          dec_i,
  input  logic          sub_i,
  input  logic          late_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o,
  output logic          zero_o,
  output logic          neg_o,
  output logic          ovf_o,
  output logic          extra_cyc_o
);
  arith_t bin_q, early_q, late_q, pick;
  logic   extra_d;

  bcd_addsub_bin u_bin (
    .a_i(acc_i), .m_i(opnd_i), .c_i(carry_i), .sub_i(sub_i), .out_o(bin_q)
  );

  bcd_addsub_dec_early u_early (
    .a_i(acc_i), .m_i(opnd_i), .c_i(carry_i), .sub_i(sub_i), .bin_i(bin_q), .out_o(early_q)
  );

  bcd_addsub_dec_late u_late (
    .a_i(acc_i), .m_i(opnd_i), .c_i(carry_i), .sub_i(sub_i), .out_o(late_q)
  );

  always_comb begin
    if (!dec_i)      pick = bin_q;
    else if (late_i) pick = late_q;
    else             pick = early_q;
    extra_d = dec_i & late_i;
  end

  generate
    if (OUT_REG) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          res_o       <= '0;
          carry_o     <= 1'b0;
          zero_o      <= 1'b0;
          neg_o       <= 1'b0;
          ovf_o       <= 1'b0;
          extra_cyc_o <= 1'b0;
        end else begin
          res_o       <= pick.res;
          carry_o     <= pick.c;
          zero_o      <= pick.z;
          neg_o       <= pick.n;
          ovf_o       <= pick.v;
          extra_cyc_o <= extra_d;
        end
      end

      // R1: binary add result one edge later
      a_r1_bin_add: assert property (@(posedge clk) disable iff (rst)
        (!dec_i && !sub_i) |=>
        res_o == DW'($past(acc_i) + $past(opnd_i) + DW'($past(carry_i))));

      // R6: early decimal subtract carry means no borrow
      a_r6_early_sub_carry: assert property (@(posedge clk) disable iff (rst)
        (dec_i && !late_i && sub_i) |=>
        carry_o == ({1'b0, $past(acc_i)} >= ({1'b0, $past(opnd_i)} + {{DW{1'b0}}, !$past(carry_i)})));

      // R9: extra cycle charged only for late decimal
      a_r9_extra_cycle: assert property (@(posedge clk) disable iff (rst)
        (dec_i && late_i) |=> extra_cyc_o);
      a_r9_no_extra: assert property (@(posedge clk) disable iff (rst)
        !(dec_i && late_i) |=> !extra_cyc_o);
    end else begin : g_comb
      always_comb begin
        res_o       = pick.res;
        carry_o     = pick.c;
        zero_o      = pick.z;
        neg_o       = pick.n;
        ovf_o       = pick.v;
        extra_cyc_o = extra_d;
      end
    end
  endgenerate
endmodule

// File: tb/bcd_addsub_tb.sv
module bcd_addsub_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] acc_i = 8'h00, opnd_i = 8'h00;
  logic       carry_i = 1'b0, dec_i = 1'b0, sub_i = 1'b0, late_i = 1'b0;
  logic [7:0] res_o;
  logic       carry_o, zero_o, neg_o, ovf_o, extra_cyc_o;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;   // 125 MHz

  bcd_addsub u_dut (
    .clk(clk), .rst(rst), .acc_i(acc_i), .opnd_i(opnd_i), .carry_i(carry_i),
    .dec_i(dec_i), .sub_i(sub_i), .late_i(late_i), .res_o(res_o), .carry_o(carry_o),
    .zero_o(zero_o), .neg_o(neg_o), .ovf_o(ovf_o), .extra_cyc_o(extra_cyc_o)
  );

  // packed {res[7:0], c, z, n, v, extra}
  function automatic logic [12:0] model(int a, int m, int c, int dec, int sub, int late);
    int r, cf, zf, nf, vf, val, t, lo, b;
    if (dec == 0) begin
      if (sub == 0) begin
        b = a + m + c; cf = (b > 255); r = b & 255;
        vf = (((a ^ m) & 128) == 0) && (((a ^ r) & 128) != 0);
      end else begin
        b = a - m - (1 - c); cf = (b >= 0); r = b & 255;
        vf = (((a ^ m) & 128) != 0) && (((a ^ r) & 128) != 0);
      end
      zf = (r == 0); nf = (r >> 7) & 1;
    end else if (late == 0) begin
      if (sub == 0) begin
        lo = (a & 15) + (m & 15) + c;
        if (lo > 9) lo += 6;
        val = (lo & 15) + (a & 240) + (m & 240) + ((lo > 15) ? 16 : 0);
        zf = (((a + m + c) & 255) == 0);
        nf = (val >> 7) & 1;
        vf = (((a ^ val) & 128) != 0) && (((a ^ m) & 128) == 0);
        if ((val & 496) > 144) val += 96;
        cf = ((val & 4080) > 240);
        r = val & 255;
      end else begin
        b = a - m - (1 - c); cf = (b >= 0);
        zf = ((b & 255) == 0); nf = (b >> 7) & 1;
        vf = (((a ^ b) & 128) != 0) && (((a ^ m) & 128) != 0);
        lo = (a & 15) - (m & 15) - (1 - c);
        if ((lo & 16) != 0) val = ((lo - 6) & 15) | ((a & 240) - (m & 240) - 16);
        else                val = (lo & 15) | ((a & 240) - (m & 240));
        if ((val & 256) != 0) val -= 96;
        r = val & 255;
      end
    end else begin
      if (sub == 0) begin
        vf = (((a ^ m) & 128) == 0);
        lo = (a & 15) + (m & 15) + c;
        if (lo >= 10) lo = 16 | ((lo + 6) & 15);
        val = lo + (a & 240) + (m & 240);
        if (val >= 160) begin cf = 1; if (val >= 384) vf = 0; val += 96; end
        else begin cf = 0; if (val < 128) vf = 0; end
      end else begin
        vf = (((a ^ m) & 128) != 0);
        t = 15 + (a & 15) - (m & 15) + c;
        if (t < 16) begin val = 0; t -= 6; end
        else begin val = 16; t -= 16; end
        val += 240 + (a & 240) - (m & 240);
        if (val < 256) begin cf = 0; if (val < 128) vf = 0; val -= 96; end
        else begin cf = 1; if (val >= 384) vf = 0; end
        val += t;
      end
      r = val & 255; zf = (r == 0); nf = (r >> 7) & 1;
    end
    return {r[7:0], cf[0], zf[0], nf[0], vf[0], 1'((dec != 0) && (late != 0))};
  endfunction

  function automatic string tag(int a, int m, int dec, int sub, int late);
    string s;
    if (dec == 0)       s = (sub != 0) ? "R2" : "R1";
    else if (late == 0) s = (sub != 0) ? "R5 R6 R9" : "R3 R4 R9";
    else                s = (sub != 0) ? "R8 R9" : "R7 R9";
    if (dec != 0 && ((a & 15) > 9 || (a >> 4) > 9 || (m & 15) > 9 || (m >> 4) > 9))
      s = {s, " R10"};
    return s;
  endfunction

  // inputs are set at a falling edge; result checked at the next falling edge (R11)
  task automatic run_vec(int a, int m, int c, int dec, int sub, int late, string extra);
    logic [12:0] exp_v, got;
    acc_i = 8'(a); opnd_i = 8'(m); carry_i = 1'(c);
    dec_i = 1'(dec); sub_i = 1'(sub); late_i = 1'(late);
    exp_v = model(a, m, c, dec, sub, late);
    @(posedge clk);
    @(negedge clk);
    got = {res_o, carry_o, zero_o, neg_o, ovf_o, extra_cyc_o};
    total++;
    if (got !== exp_v) begin
      bad++;
      $display("FAIL %s%s a=%h m=%h c=%0d dec=%0d sub=%0d late=%0d got=%h exp=%h",
               tag(a, m, dec, sub, late), extra, a, m, c, dec, sub, late, got, exp_v);
    end
  endtask

  initial begin
    int opl[16] = '{8'h00, 8'h01, 8'h09, 8'h0A, 8'h0F, 8'h10, 8'h19, 8'h50,
                    8'h7F, 8'h80, 8'h99, 8'h9A, 8'hA5, 8'hF0, 8'hFA, 8'hFF};
    // R11: reset clears outputs even with live inputs
    acc_i = 8'hFF; opnd_i = 8'h01; carry_i = 1'b1; dec_i = 1'b1; late_i = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if ({res_o, carry_o, zero_o, neg_o, ovf_o, extra_cyc_o} !== 13'h0) begin
      bad++;
      $display("FAIL R11 reset got=%h exp=0", {res_o, carry_o, zero_o, neg_o, ovf_o, extra_cyc_o});
    end
    rst = 1'b0;
    // R11: nothing moves before the clock edge
    acc_i = 8'h01; opnd_i = 8'h02; carry_i = 1'b0; dec_i = 1'b0; sub_i = 1'b0; late_i = 1'b0;
    #1;
    total++;
    if (res_o !== 8'h00) begin
      bad++;
      $display("FAIL R11 early update got=%h exp=00", res_o);
    end
    run_vec(1, 2, 0, 0, 0, 0, " R11");
    // near-exhaustive sweep: all A against nibble-rich operands, all modes
    for (int mode = 0; mode < 16; mode++)
      for (int mi = 0; mi < 16; mi++)
        for (int a = 0; a < 256; a++)
          run_vec(a, opl[mi], mode & 1, (mode >> 1) & 1, (mode >> 2) & 1, (mode >> 3) & 1, "");
    // R12: every pair of valid BCD bytes in decimal mode
    for (int mode = 0; mode < 8; mode++)
      for (int x = 0; x < 100; x++)
        for (int y = 0; y < 100; y++)
          run_vec(((x / 10) << 4) | (x % 10), ((y / 10) << 4) | (y % 10),
                  mode & 1, 1, (mode >> 1) & 1, (mode >> 2) & 1, " R12");
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog R11 got=timeout exp=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule